// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit descriptors held in shared memory. It rests until a poll-demand pulse arrives. Then it fetches the descriptor at its current pointer. If that descriptor is owned by the hardware, the walker streams the referenced buffer out as bytes and hands the descriptor back to software by writing its control word with the ownership bit cleared. It then moves the pointer on and repeats, until it meets a descriptor that software still owns or a descriptor it refuses to process.

Each descriptor takes 32 bytes, laid out as eight little-endian words:

| Word | Contents |
| --- | --- |
| 0 | Control word |
| 1 | Two 16-bit size fields |
| 2 | First buffer address |
| 3 | Second buffer address |
| 4 | Extended status |
| 5 to 7 | Reserved |

Only words 0 to 2 are read. Software sets a ring base with a one-cycle load strobe, and that also resets the current pointer. Memory is reached through one word-wide request/ready port. Bytes leave on a valid/ready stream, with a last flag on the final byte of a frame. A one-cycle event marks every finished frame. Elsewhere in the chip this event sets both the transmit-complete status and the normal-summary status.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset the walker issues no memory request and drives no stream byte and no event. It stays that way until `poll_i` pulses.
- R2: For each descriptor the walker reads three words:
  - the control word at pointer+0;
  - the size word at pointer+4, where the first length is bits 11:0 and the second length is bits 27:16;
  - the buffer address at pointer+8.

  A control word with bit 31 (ownership) at 0 ends the scan. That descriptor is not written.
- R3: The buffer bytes leave in ascending address order, starting at any byte address. Byte k of a word is bits 8k+7:8k. `tx_last_o` is high only on the final byte of a descriptor whose control bit 29 (last segment) is set.
- R4: While `tx_ready_i` is low, a presented byte stays valid with unchanged data and last flag.
- R5: After a descriptor's bytes are all accepted, the walker writes only its control word back. Bit 31 is cleared and every other bit is kept. The other seven words are never written.
- R6: After the write-back, the pointer moves to the ring base if control bit 21 (end of ring) is set, and otherwise moves up by 32.
- R7: If the first length exceeds 2048, or the second length is non-zero, the scan stops. No byte is sent, nothing is written, and the pointer stays put, so the next poll starts on the same descriptor.
- R8: The running byte count of the current frame is cleared at the start of each scan and after each last segment. A descriptor is rejected as in R7 when that count plus its length reaches 8192 or more. 8191 is accepted.
- R9: `frame_done_o` pulses for exactly one cycle per last-segment descriptor. The pulse comes after that descriptor's final byte and coincides with its write-back request.
- R10: A poll pulse that arrives while a scan runs causes exactly one further scan, which starts from the current pointer. Several such pulses still cause only one further scan.
- R11: `base_wr_i` loads the ring base and the current pointer only while the walker is idle. While a scan runs, the strobe is ignored.
- R12: A memory request keeps its address, write enable and write data steady until `mem_ready_i` is seen high. All addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_i | input | 1 | Load strobe for ring base and current pointer |
| base_addr_i | input | AW | Ring base byte address (32-byte aligned) |
| poll_i | input | 1 | Poll-demand pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_ready_i | input | 1 | Stream sink ready |
| frame_done_o | output | 1 | One-cycle frame-complete event |

## Verification
Directed rings cover four cases:
- Short single-segment frames at unaligned buffer addresses, which separate correct lane selection from word-granular copying.
- Multi-segment frames, which separate per-segment last flags from per-frame last flags.
- An end-of-ring descriptor, which separates a wrap to the base from linear advance.
- Sizes of 2048 against 2049, a non-zero second length, and running totals of 8191 against 8192, which pin the rejection thresholds and show that a rejected descriptor is left untouched and re-read.

Random rings of mixed lengths, flags and stop conditions are run with random memory and sink back-pressure. Every result is compared against a bench-side walk of the same memory image, including the address of the first read of each scan. A burst of polls during a scan, and a base load during a scan, are compared by counting re-reads of the stopping descriptor and by checking where the following scan begins.

// File: rtl/twalk_pkg.sv
package twalk_pkg;
  // control word bit positions (decoded by software sharing the ring)
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 29;
  localparam int EOR_BIT  = 21;
  // size word layout
  localparam int SIZE_LEN_W = 12;
  localparam int SIZE2_LSB  = 16;
  // byte offsets of the words the walker reads
  localparam int OFS_CTL  = 0;
  localparam int OFS_SIZE = 4;
  localparam int OFS_BUF  = 8;

  typedef enum logic [2:0] {
    C_IDLE, C_RD_CTL, C_RD_SIZE, C_RD_ADDR, C_CHECK, C_STREAM, C_WRBACK
  } ctrl_state_e;

  typedef enum logic [1:0] {
    S_IDLE, S_FETCH, S_EMIT
  } strm_state_e;
endpackage

// File: rtl/twalk_ptr.sv
module twalk_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= load_val_i;
      cur_q  <= load_val_i;
    end else if (adv_i) begin
      cur_q <= wrap_i ? base_q : cur_q + AW'(STEP);
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/twalk_stream.sv
module twalk_stream
  import twalk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             last_seg_i,
  output logic             done_o,
  output logic             req_o,
  output logic [AW-1:0]    addr_o,
  input  logic             ready_i,
  input  logic [31:0]      rdata_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  input  logic             tx_ready_i
);
  strm_state_e      st_q;
  logic [AW-1:0]    bptr_q;
  logic [LEN_W-1:0] left_q;
  logic [31:0]      word_q;
  logic             seg_last_q;
  logic [1:0]       lane_nxt;

  function automatic logic [7:0] lane_sel(input logic [31:0] w, input logic [1:0] l);
    return w[{l, 3'b000} +: 8];
  endfunction

  assign lane_nxt = bptr_q[1:0] + 2'd1;
  assign addr_o   = {bptr_q[AW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      bptr_q     <= '0;
      left_q     <= '0;
      word_q     <= '0;
      seg_last_q <= 1'b0;
      req_o      <= 1'b0;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
      tx_last_o  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            if (len_i == '0) begin
              done_o <= 1'b1;
            end else begin
              bptr_q     <= addr_i;
              left_q     <= len_i;
              seg_last_q <= last_seg_i;
              req_o      <= 1'b1;
              st_q       <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (ready_i) begin
            req_o      <= 1'b0;
            word_q     <= rdata_i;
            tx_data_o  <= lane_sel(rdata_i, bptr_q[1:0]);
            tx_valid_o <= 1'b1;
            tx_last_o  <= seg_last_q && (left_q == LEN_W'(1));
            st_q       <= S_EMIT;
          end
        end
        S_EMIT: begin
          if (tx_ready_i) begin
            bptr_q <= bptr_q + AW'(1);
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) begin
              tx_valid_o <= 1'b0;
              tx_last_o  <= 1'b0;
              done_o     <= 1'b1;
              st_q       <= S_IDLE;
            end else if (bptr_q[1:0] == 2'b11) begin
              tx_valid_o <= 1'b0;
              tx_last_o  <= 1'b0;
              req_o      <= 1'b1;
              st_q       <= S_FETCH;
            end else begin
              tx_data_o <= lane_sel(word_q, lane_nxt);
              tx_last_o <= seg_last_q && (left_q == LEN_W'(2));
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twalk_ctrl.sv
module twalk_ctrl
  import twalk_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 12,
  parameter int MAX_BUF   = 2048,
  parameter int MAX_FRAME = 8192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             poll_i,
  input  logic [AW-1:0]    cur_i,
  output logic             idle_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             str_start_o,
  output logic [AW-1:0]    str_addr_o,
  output logic [LEN_W-1:0] str_len_o,
  output logic             str_last_o,
  input  logic             str_done_i,
  output logic             evt_o
);
  localparam int ACC_W = $clog2(MAX_FRAME) + 1;
  localparam logic [LEN_W:0] BUF_LIM   = (LEN_W + 1)'(MAX_BUF);
  localparam logic [ACC_W-1:0] FRM_LIM = ACC_W'(MAX_FRAME);

  ctrl_state_e      st_q;
  logic [31:0]      ctl_q;
  logic [LEN_W-1:0] len1_q;
  logic [LEN_W-1:0] len2_q;
  logic [AW-1:0]    baddr_q;
  logic [ACC_W-1:0] acc_q;
  logic             pend_q;
  logic             restart;
  logic             reject;
  logic [ACC_W-1:0] acc_sum;

  assign restart = pend_q | poll_i;
  assign acc_sum = acc_q + ACC_W'(len1_q);
  assign reject  = ({1'b0, len1_q} > BUF_LIM) || (len2_q != '0) || (acc_sum >= FRM_LIM);

  always_comb begin
    case (st_q)
      C_RD_SIZE: mem_addr_o = cur_i + AW'(OFS_SIZE);
      C_RD_ADDR: mem_addr_o = cur_i + AW'(OFS_BUF);
      default:   mem_addr_o = cur_i + AW'(OFS_CTL);
    endcase
  end

  assign mem_wdata_o = ctl_q & ~(32'd1 << OWN_BIT);
  assign idle_o      = (st_q == C_IDLE);
  assign adv_o       = (st_q == C_WRBACK) && mem_ready_i;
  assign wrap_o      = ctl_q[EOR_BIT];
  assign str_addr_o  = baddr_q;
  assign str_len_o   = len1_q;
  assign str_last_o  = ctl_q[LAST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= C_IDLE;
      ctl_q       <= '0;
      len1_q      <= '0;
      len2_q      <= '0;
      baddr_q     <= '0;
      acc_q       <= '0;
      pend_q      <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      str_start_o <= 1'b0;
      evt_o       <= 1'b0;
    end else begin
      str_start_o <= 1'b0;
      evt_o       <= 1'b0;
      if (poll_i && st_q != C_IDLE) pend_q <= 1'b1;
      case (st_q)
        C_IDLE: begin
          if (poll_i) begin
            acc_q     <= '0;
            mem_req_o <= 1'b1;
            mem_we_o  <= 1'b0;
            st_q      <= C_RD_CTL;
          end
        end
        C_RD_CTL: begin
          if (mem_ready_i) begin
            ctl_q <= mem_rdata_i;
            if (!mem_rdata_i[OWN_BIT]) begin
              pend_q    <= 1'b0;
              acc_q     <= '0;
              mem_req_o <= restart;
              if (!restart) st_q <= C_IDLE;
            end else begin
              st_q <= C_RD_SIZE;
            end
          end
        end
        C_RD_SIZE: begin
          if (mem_ready_i) begin
            len1_q <= mem_rdata_i[LEN_W-1:0];
            len2_q <= mem_rdata_i[SIZE2_LSB +: LEN_W];
            st_q   <= C_RD_ADDR;
          end
        end
        C_RD_ADDR: begin
          if (mem_ready_i) begin
            baddr_q   <= mem_rdata_i[AW-1:0];
            mem_req_o <= 1'b0;
            st_q      <= C_CHECK;
          end
        end
        C_CHECK: begin
          if (reject) begin
            pend_q    <= 1'b0;
            acc_q     <= '0;
            mem_req_o <= restart;
            st_q      <= restart ? C_RD_CTL : C_IDLE;
          end else begin
            str_start_o <= 1'b1;
            st_q        <= C_STREAM;
          end
        end
        C_STREAM: begin
          if (str_done_i) begin
            if (ctl_q[LAST_BIT]) begin
              acc_q <= '0;
              evt_o <= 1'b1;
            end else begin
              acc_q <= acc_sum;
            end
            mem_req_o <= 1'b1;
            mem_we_o  <= 1'b1;
            st_q      <= C_WRBACK;
          end
        end
        C_WRBACK: begin
          if (mem_ready_i) begin
            mem_we_o <= 1'b0;
            st_q     <= C_RD_CTL;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int AW         = 32,
  parameter int MAX_BUF    = 2048,
  parameter int MAX_FRAME  = 8192,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          poll_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          frame_done_o
);
  localparam int LEN_W = twalk_pkg::SIZE_LEN_W;

  logic             idle;
  logic             adv;
  logic             wrap;
  logic [AW-1:0]    cur;
  logic             c_req;
  logic             c_we;
  logic [AW-1:0]    c_addr;
  logic [31:0]      c_wdata;
  logic             s_req;
  logic [AW-1:0]    s_addr;
  logic             s_start;
  logic [AW-1:0]    s_baddr;
  logic [LEN_W-1:0] s_len;
  logic             s_last;
  logic             s_done;

  twalk_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (base_wr_i && idle),
    .load_val_i (base_addr_i),
    .adv_i      (adv),
    .wrap_i     (wrap),
    .cur_o      (cur)
  );

  twalk_ctrl #(.AW(AW), .LEN_W(LEN_W), .MAX_BUF(MAX_BUF), .MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .poll_i      (poll_i),
    .cur_i       (cur),
    .idle_o      (idle),
    .adv_o       (adv),
    .wrap_o      (wrap),
    .mem_req_o   (c_req),
    .mem_we_o    (c_we),
    .mem_addr_o  (c_addr),
    .mem_wdata_o (c_wdata),
    .mem_ready_i (mem_ready_i && c_req),
    .mem_rdata_i (mem_rdata_i),
    .str_start_o (s_start),
    .str_addr_o  (s_baddr),
    .str_len_o   (s_len),
    .str_last_o  (s_last),
    .str_done_i  (s_done),
    .evt_o       (frame_done_o)
  );

  twalk_stream #(.AW(AW), .LEN_W(LEN_W)) u_stream (
    .clk        (clk),
    .rst        (rst),
    .start_i    (s_start),
    .addr_i     (s_baddr),
    .len_i      (s_len),
    .last_seg_i (s_last),
    .done_o     (s_done),
    .req_o      (s_req),
    .addr_o     (s_addr),
    .ready_i    (mem_ready_i && s_req),
    .rdata_i    (mem_rdata_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_last_o  (tx_last_o),
    .tx_ready_i (tx_ready_i)
  );

  // controller and streamer never request in the same cycle
  assign mem_req_o   = c_req | s_req;
  assign mem_addr_o  = s_req ? s_addr : c_addr;
  assign mem_we_o    = c_we & c_req;
  assign mem_wdata_o = c_wdata;
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ready_i,
  input logic [7:0]    tx_data_o,
  input logic          tx_valid_o,
  input logic          tx_last_o,
  input logic          tx_ready_i,
  input logic          frame_done_o
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !mem_req_o && !tx_valid_o && !frame_done_o);

  p_last_has_valid_r3: assert property (@(posedge clk) disable iff (rst)
    tx_last_o |-> tx_valid_o);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  p_write_after_stream_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> !tx_valid_o);

  p_evt_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o);

  p_evt_with_wb_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> mem_req_o && mem_we_o && !tx_valid_o);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));

  p_addr_align_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

bind tx_ring_walker tx_ring_walker_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i),
  .tx_data_o    (tx_data_o),
  .tx_valid_o   (tx_valid_o),
  .tx_last_o    (tx_last_o),
  .tx_ready_i   (tx_ready_i),
  .frame_done_o (frame_done_o)
);

// File: tb/tx_ring_walker_tb_top.sv
module tx_ring_walker_tb_top;
  localparam int AW = 32;
  localparam int MEM_WORDS = 2048;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          base_wr = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          poll = 1'b0;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [7:0]    tx_data;
  logic          tx_valid, tx_last, tx_ready;
  logic          frame_done;

  logic [31:0] mem  [MEM_WORDS];
  logic [31:0] rmem [MEM_WORDS];

  assign mem_rdata = mem[mem_addr[12:2]];

  tx_ring_walker dut_i (
    .clk(clk), .rst(rst), .base_wr_i(base_wr), .base_addr_i(base_addr), .poll_i(poll),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready),
    .frame_done_o(frame_done)
  );

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int rdy_pct = 75;
  int snk_pct = 75;
  int quiet = 0;
  int rd_count = 0;
  int evt_cnt = 0;
  int exp_evt = 0;
  int watch_reads = 0;
  logic [AW-1:0] watch_addr = '1;
  bit got_first = 0;
  logic [AW-1:0] first_addr = '0;
  logic [AW-1:0] m_base = '0;
  logic [AW-1:0] m_cur = '0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  // memory and sink model: choose handshakes, then record them
  always @(negedge clk) begin
    mem_ready = !rst && (($urandom % 100) < rdy_pct);
    tx_ready  = !rst && (($urandom % 100) < snk_pct);
    #1;
    if (!rst) begin
      if (mem_req && mem_ready) begin
        if (mem_we) mem[mem_addr[12:2]] = mem_wdata;
        else begin
          rd_count++;
          if (!got_first) begin got_first = 1; first_addr = mem_addr; end
          if (mem_addr == watch_addr) watch_reads++;
        end
      end
      if (tx_valid && tx_ready) got_q.push_back({tx_last, tx_data});
      if (frame_done) evt_cnt++;
      if (mem_req || tx_valid) quiet = 0; else quiet++;
    end
  end

  task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] v);
    mem[a[12:2]] = v;
    rmem[a[12:2]] = v;
  endtask

  task automatic put_desc(input logic [AW-1:0] a, input logic [31:0] ctl,
                          input int l1, input int l2, input logic [31:0] ba);
    wr_word(a, ctl);
    wr_word(a + 4, {4'h0, 12'(l2), 4'h0, 12'(l1)});
    wr_word(a + 8, ba);
    for (int k = 3; k < 8; k++) wr_word(a + 4 * k, $urandom);
  endtask

  function automatic logic [31:0] mk_ctl(input bit own, input bit last, input bit eor);
    return (32'(own) << 31) | (32'(last) << 29) | (32'(eor) << 21) | ($urandom & 32'h001f_ffff);
  endfunction

  // bench-side walk of the ring per the requirements
  task automatic model_scan();
    int acc = 0;
    forever begin
      logic [31:0] ctl, sz, ba;
      int l1, l2;
      ctl = rmem[m_cur[12:2]];
      if (!ctl[31]) break;
      sz = rmem[m_cur[12:2] + 11'd1];
      ba = rmem[m_cur[12:2] + 11'd2];
      l1 = int'(sz[11:0]);
      l2 = int'(sz[27:16]);
      if (l1 > 2048 || l2 != 0 || acc + l1 >= 8192) break;
      for (int i = 0; i < l1; i++) begin
        logic [31:0] a, w;
        a = ba + 32'(i);
        w = rmem[a[12:2]];
        exp_q.push_back({ctl[29] && (i == l1 - 1), w[{a[1:0], 3'b000} +: 8]});
      end
      if (ctl[29]) begin acc = 0; exp_evt++; end
      else acc += l1;
      rmem[m_cur[12:2]] = ctl & 32'h7fff_ffff;
      m_cur = ctl[21] ? m_base : m_cur + 32;
    end
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic load_base(input logic [AW-1:0] a);
    @(negedge clk); base_wr = 1'b1; base_addr = a;
    @(negedge clk); base_wr = 1'b0;
    m_base = a;
    m_cur = a;
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    quiet = 0;
    while (quiet < 14) @(negedge clk);
  endtask

  task automatic prep();
    exp_q.delete();
    got_q.delete();
    exp_evt = 0;
    evt_cnt = 0;
    got_first = 0;
  endtask

  task automatic compare(input string tag, input logic [AW-1:0] start);
    int bad = -1;
    int diff = 0;
    chk(got_first && first_addr == start, {tag, " first read address (R2 R6 R7 R11)"},
        first_addr, start);
    chk(got_q.size() == exp_q.size(), {tag, " byte count (R3 R7 R8)"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    chk(bad < 0, {tag, " byte data/last (R3)"},
        bad < 0 ? 0 : got_q[bad], bad < 0 ? 0 : exp_q[bad]);
    chk(evt_cnt == exp_evt, {tag, " frame events (R9)"}, evt_cnt, exp_evt);
    for (int w = 0; w < MEM_WORDS; w++) if (mem[w] !== rmem[w]) diff++;
    chk(diff == 0, {tag, " memory after write-back (R5 R7)"}, diff, 0);
  endtask

  task automatic run_scan(input string tag);
    logic [AW-1:0] start;
    prep();
    start = m_cur;
    model_scan();
    pulse_poll();
    wait_quiet();
    compare(tag, start);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < MEM_WORDS; w++) begin
      logic [31:0] v;
      v = (w < 256) ? 32'h0 : $urandom;
      mem[w] = v;
      rmem[w] = v;
    end
    mem_ready = 1'b0;
    tx_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(!mem_req && !tx_valid && !frame_done, "R1 outputs quiet after reset",
        {mem_req, tx_valid, frame_done}, 0);
    repeat (40) @(negedge clk);
    chk(rd_count == 0, "R1 no memory reads without poll", rd_count, 0);

    // directed: single and multi segment frames, unaligned buffers
    load_base(32'h0);
    put_desc(32'h000, mk_ctl(1, 1, 0), 5, 0, 32'h401);
    put_desc(32'h020, mk_ctl(1, 1, 0), 8, 0, 32'h800);
    put_desc(32'h040, mk_ctl(1, 0, 0), 3, 0, 32'h903);
    put_desc(32'h060, mk_ctl(1, 1, 0), 1, 0, 32'hA02);
    put_desc(32'h080, mk_ctl(0, 1, 0), 4, 0, 32'hB00);
    run_scan("R2 R3 R5 R6 directed ring");

    // end of ring wrap back to base
    snk_pct = 40;
    load_base(32'h100);
    put_desc(32'h100, mk_ctl(1, 1, 0), 4, 0, 32'hC00);
    put_desc(32'h120, mk_ctl(1, 1, 1), 6, 0, 32'hC13);
    put_desc(32'h140, mk_ctl(1, 1, 0), 6, 0, 32'hC20);
    run_scan("R6 end-of-ring wrap");
    run_scan("R6 rescan after wrap starts at base");
    snk_pct = 75;

    // size rejection and boundary
    load_base(32'h200);
    put_desc(32'h200, mk_ctl(1, 1, 0), 2049, 0, 32'h400);
    put_desc(32'h220, mk_ctl(1, 1, 0), 4, 1, 32'h400);
    put_desc(32'h240, mk_ctl(0, 0, 0), 0, 0, 32'h0);
    run_scan("R7 first length 2049 rejected");
    wr_word(32'h204, {16'h0, 16'd2048});
    run_scan("R7 first length 2048 accepted");
    run_scan("R7 non-zero second length rejected");

    // frame accumulation limit
    snk_pct = 95; rdy_pct = 95;
    load_base(32'h300);
    for (int k = 0; k < 4; k++) put_desc(32'h300 + 32 * k, mk_ctl(1, 0, 0), 2048, 0, 32'h400 + 32'(k));
    put_desc(32'h380, mk_ctl(0, 0, 0), 0, 0, 32'h0);
    run_scan("R8 total reaching 8192 halts");
    run_scan("R8 count cleared at scan start");
    load_base(32'h300);
    for (int k = 0; k < 3; k++) put_desc(32'h300 + 32 * k, mk_ctl(1, 0, 0), 2048, 0, 32'h800);
    put_desc(32'h360, mk_ctl(1, 1, 0), 2047, 0, 32'h801);
    put_desc(32'h380, mk_ctl(0, 0, 0), 0, 0, 32'h0);
    run_scan("R8 total of 8191 accepted");
    snk_pct = 75; rdy_pct = 75;

    // polls and base load during a scan
    load_base(32'h0);
    for (int k = 0; k < 3; k++) put_desc(32'h20 * k, mk_ctl(1, 1, 0), 10, 0, 32'h500 + 32'(k));
    put_desc(32'h060, mk_ctl(0, 0, 0), 0, 0, 32'h0);
    prep();
    watch_addr = 32'h060;
    watch_reads = 0;
    model_scan();
    pulse_poll();
    @(negedge clk);
    pulse_poll();
    pulse_poll();
    @(negedge clk); base_wr = 1'b1; base_addr = 32'h1000;
    @(negedge clk); base_wr = 1'b0;
    wait_quiet();
    compare("R10 polls while busy", 32'h0);
    chk(watch_reads == 2, "R10 exactly one extra scan", watch_reads, 2);
    watch_addr = '1;
    run_scan("R11 base load ignored while busy");

    // random rings
    for (int r = 0; r < 24; r++) begin
      int n;
      logic [AW-1:0] b;
      n = 1 + int'($urandom % 6);
      b = 32'(($urandom % (32 - (n + 1))) * 32);
      rdy_pct = 30 + int'($urandom % 70);
      snk_pct = 30 + int'($urandom % 70);
      load_base(b);
      for (int k = 0; k < n; k++) begin
        bit last, eor;
        int l1, l2;
        last = (k == n - 1) || ($urandom % 2 == 1);
        eor = (k == n - 1) && ($urandom % 3 == 0);
        l1 = int'($urandom % 41);
        l2 = 0;
        if ($urandom % 12 == 0) l1 = 2049 + int'($urandom % 100);
        if ($urandom % 12 == 0) l2 = 1 + int'($urandom % 7);
        put_desc(b + 32'(32 * k), mk_ctl(1, last, eor), l1, l2,
                 32'h400 + ($urandom % 32'h1800));
      end
      put_desc(b + 32'(32 * n), mk_ctl(0, 0, 0), 0, 0, 32'h0);
      run_scan("R2 R3 R4 R5 R6 random ring");
    end

    summary();
    $finish;
  end
endmodule